// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Driver

This block places one module's interrupt request on a shared bus of eight request lines. The bus carries thirty-two interrupt levels. It does this by cycling through four time slots, and each slot carries a group of eight levels. A bus slot indicator input gives the group that is active in the current cycle. The module has a configuration made of two fields: a 2-bit slot field that picks a group, and a 3-bit line field that picks one of the eight lines within that group. The effective interrupt level is therefore slot × 8 + line.

While a request is pending, the block drives the selected line high in the cycles where the bus slot indicator equals the configured slot. In all other cycles it drives every line low. The outputs are registered.

Software writes a new configuration through a small write port, and the new value is held in a staging register. It is copied into the active configuration only at a slot boundary, which is any cycle where the slot indicator differs from its value in the cycle before. Because of this, a change never cuts a slot in the middle. The block applies no hardware priority among sources. When several sources share one level, software tells them apart.

Top module: `irq_slot_driver`

## Requirements
- R1: After reset all request lines are low, and the active and staged configuration are slot 0, line 0.
- R2: If the request is pending in a cycle and the bus slot indicator equals the active slot field, then after the next clock edge exactly bit `line` of `irqLines` is high (bit 0 = line 0).
- R3: If the bus slot indicator differs from the active slot field in a cycle, all request lines are low after the next clock edge, whatever the request.
- R4: If no request is pending in a cycle, all request lines are low after the next clock edge.
- R5: The outputs are registered. They reflect the inputs sampled at the previous clock edge and do not change between edges.
- R6: A configuration write is held in a staging register. It becomes active at the first slot boundary after the write cycle, and that boundary cycle already uses the new value. A slot boundary is a cycle in which `busSlot` differs from its value in the cycle before; the cycle right after reset compares against slot 0.
- R7: A write made in the same cycle as a slot boundary is not applied at that boundary. It is applied at the following one.
- R8: Level N (0 to 31) is driven as line N mod 8 during bus slot N div 8. Bus slot 00 carries levels 0–7, 01 carries 8–15, 10 carries 16–23, and 11 carries 24–31.
- R9: At most one request line is high at any time.
- R10: If several writes happen between two boundaries, only the last one becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqPending | input | 1 | Module interrupt request is pending |
| busSlot | input | 2 | Slot indicator: group of eight levels currently on the bus |
| cfgWrEn | input | 1 | Write strobe for the configuration |
| cfgWrLine | input | 3 | Line within the group, for the write |
| cfgWrSlot | input | 2 | Slot selector, for the write |
| irqLines | output | 8 | Active-high one-hot request lines |

## Verification
The bench targets the timing of configuration changes: a write followed at once by a boundary, a write in the boundary cycle itself, and several writes inside one slot. A design that applied writes immediately, or read the staged value one cycle late, would drive the wrong line or the wrong slot in those cycles. It also sweeps the level numbers across all four groups to catch a swapped mapping of slot to group. It drops the request in the middle of a slot to show that the line goes low one edge later and not in the same cycle.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;
  localparam int LINES  = 8;
  localparam int SLOTS  = 4;
  localparam int LINE_W = $clog2(LINES);
  localparam int SLOT_W = $clog2(SLOTS);

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [LINE_W-1:0] line;
  } irqCfg_t;

  typedef struct packed {
    logic stageWr;  // capture a written configuration
    logic commit;   // slot boundary: staged -> active
  } irqStrobe_t;
endpackage

// File: rtl/irq_slot_ctrl.sv
module irq_slot_ctrl
  import irq_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] busSlot,
  input  logic              cfgWrEn,
  output irqStrobe_t        strobe
);
  logic [SLOT_W-1:0] prevSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSlot <= '0;
    else       prevSlot <= busSlot;
  end

  always_comb begin
    strobe.commit  = (busSlot != prevSlot);
    strobe.stageWr = cfgWrEn;
  end

  // R6: a commit only happens where the slot indicator moved
  assert_commit_on_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (prevSlot != $past(prevSlot)));
endmodule

// File: rtl/irq_slot_datapath.sv
module irq_slot_datapath
  import irq_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic              reqPending,
  input  logic [SLOT_W-1:0] busSlot,
  input  irqCfg_t           wrCfg,
  output logic [LINES-1:0]  irqLines
);
  irqCfg_t stagedCfg, activeCfg, useCfg;
  logic    slotHit;
  logic [LINES-1:0] nextLines;

  always_comb begin
    useCfg  = strobe.commit ? stagedCfg : activeCfg;
    slotHit = reqPending && (busSlot == useCfg.slot);
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign nextLines[i] = slotHit && (useCfg.line == LINE_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedCfg <= '0;
      activeCfg <= '0;
      irqLines  <= '0;
    end else begin
      if (strobe.stageWr) stagedCfg <= wrCfg;
      if (strobe.commit)  activeCfg <= stagedCfg;
      irqLines <= nextLines;
    end
  end

  // R9: never more than one line
  assert_one_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));
  // R4: no request means quiet bus next cycle
  assert_quiet_no_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    !reqPending |=> (irqLines == '0));
  // R6: active configuration holds between boundaries
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeCfg));
  // R7: a write never reaches the active set in its own cycle
  assert_write_deferred_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stageWr && strobe.commit) |=> (activeCfg == $past(stagedCfg)));
endmodule

// File: rtl/irq_slot_driver.sv
module irq_slot_driver
  import irq_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqPending,
  input  logic [SLOT_W-1:0] busSlot,
  input  logic              cfgWrEn,
  input  logic [LINE_W-1:0] cfgWrLine,
  input  logic [SLOT_W-1:0] cfgWrSlot,
  output logic [LINES-1:0]  irqLines
);
  irqStrobe_t strobe;
  irqCfg_t    wrCfg;

  assign wrCfg.slot = cfgWrSlot;
  assign wrCfg.line = cfgWrLine;

  irq_slot_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busSlot(busSlot), .cfgWrEn(cfgWrEn), .strobe(strobe)
  );

  irq_slot_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqPending(reqPending),
    .busSlot(busSlot), .wrCfg(wrCfg), .irqLines(irqLines)
  );
endmodule

// File: tb/test_irq_slot_driver.sv
module test_irq_slot_driver;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqPending = 1'b0;
  logic [1:0] busSlot = 2'd0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgWrLine = 3'd0;
  logic [1:0] cfgWrSlot = 2'd0;
  logic [7:0] irqLines;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state, built from the requirements
  logic [1:0] mPrev, mStSlot, mActSlot;
  logic [2:0] mStLine, mActLine;
  logic [7:0] expLines;

  always #10 clk = ~clk;  // 50 MHz

  irq_slot_driver i_irq_slot_driver (
    .clk(clk), .rstN(rstN), .reqPending(reqPending), .busSlot(busSlot),
    .cfgWrEn(cfgWrEn), .cfgWrLine(cfgWrLine), .cfgWrSlot(cfgWrSlot),
    .irqLines(irqLines)
  );

  function automatic logic [7:0] lineFor(input logic req, input logic [1:0] bs,
                                         input logic [1:0] s, input logic [2:0] l);
    return (req && bs == s) ? (8'd1 << l) : 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irqLines=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, sample after the edge
  task automatic step(input logic req, input logic [1:0] bs, input logic wr,
                      input logic [2:0] wl, input logic [1:0] ws, input string tag);
    logic [1:0] us;
    logic [2:0] ul;
    @(negedge clk);
    reqPending = req; busSlot = bs; cfgWrEn = wr; cfgWrLine = wl; cfgWrSlot = ws;
    if (bs != mPrev) begin us = mStSlot; ul = mStLine; end
    else             begin us = mActSlot; ul = mActLine; end
    expLines = lineFor(req, bs, us, ul);
    if (bs != mPrev) begin mActSlot = mStSlot; mActLine = mStLine; end
    if (wr) begin mStSlot = ws; mStLine = wl; end
    mPrev = bs;
    @(posedge clk);
    #2;
    if (tag == "") begin
      if (expLines != 0) check("R2", irqLines, expLines);
      else if (!req)     check("R4", irqLines, expLines);
      else               check("R3", irqLines, expLines);
    end else check(tag, irqLines, expLines);
  endtask

  initial begin
    #(20 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mPrev = 0; mStSlot = 0; mStLine = 0; mActSlot = 0; mActLine = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", irqLines, 8'd0);
    @(negedge clk); rstN = 1'b1;

    // R1: reset config is slot 0 line 0
    step(1, 2'd0, 0, 0, 0, "R1 default cfg");
    step(1, 2'd1, 0, 0, 0, "R3");

    // R8: sweep levels across the four groups
    for (int n = 3; n < 32; n += 7) begin
      step(0, 2'd1, 1, 3'(n % 8), 2'(n / 8), "R4");
      step(0, 2'd2, 0, 0, 0, "R4");          // boundary commits
      for (int s = 0; s < 4; s++) step(1, 2'(s), 0, 0, 0, "R8 level map");
    end

    // R6: write then boundary right after; boundary cycle uses new cfg
    step(1, 2'd3, 0, 0, 0, "");
    step(1, 2'd3, 1, 3'd5, 2'd3, "R6 not yet");   // same slot, old active
    step(1, 2'd3, 0, 0, 0, "R6 not yet");
    step(1, 2'd0, 0, 0, 0, "R6 boundary");
    step(1, 2'd3, 0, 0, 0, "R6 applied");

    // R7: write in the boundary cycle is deferred
    step(1, 2'd1, 1, 3'd2, 2'd1, "R7 deferred");
    step(1, 2'd1, 0, 0, 0, "R7 deferred");
    step(1, 2'd0, 0, 0, 0, "R7");
    step(1, 2'd1, 0, 0, 0, "R7 applied");

    // R10: several writes in one slot, last wins
    step(1, 2'd2, 1, 3'd1, 2'd0, "R10");
    step(1, 2'd2, 1, 3'd6, 2'd2, "R10");
    step(1, 2'd2, 1, 3'd7, 2'd2, "R10");
    step(1, 2'd3, 0, 0, 0, "R10");
    step(1, 2'd2, 0, 0, 0, "R10 last write");

    // R5: output holds between edges and follows one edge later
    step(1, 2'd2, 0, 0, 0, "R5");
    @(negedge clk); reqPending = 1'b0;
    #3; check("R5 holds before edge", irqLines, 8'b1000_0000);
    @(posedge clk); #2; check("R5 after edge", irqLines, 8'd0);
    mPrev = 2'd2;

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic wr;
      wr = ($urandom % 5) == 0;
      step(($urandom % 4) != 0, 2'(($urandom % 3 == 0) ? $urandom : busSlot),
           wr, 3'($urandom), 2'($urandom), "");
      checks++;
      if (!$onehot0(irqLines)) begin
        fails++;
        $display("FAIL R9: irqLines=%b expected at most one bit", irqLines);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule